// File: doc/BRIEF.md
# Shadowed Word Memory with Byte Lanes

This block is a behavioural model of a word-wide memory built from two arrays of equal size. One is a fast volatile array that the host reads and writes. The other is a nonvolatile shadow that keeps one copy of every word. The host uses an SRAM-style port: an active-low chip select, output enable and write enable, an active-low hold line, and two active-low byte-lane selects on a 16-bit data bus. Read data is combinational, so it follows the address. Writes are taken on the rising clock edge.

Two command inputs move the whole memory between the arrays in one parallel copy. A save command copies the volatile array into the shadow. A restore command copies the shadow back into the volatile array. Each transfer keeps the block busy for `XFER_CYCLES` clock cycles, and all host access is locked out for that time. A restore also runs by itself after reset, before any access is accepted. A saturating counter records completed saves and raises a wear flag once the count passes the endurance limit.

The controller is a four-state machine (`XS_BOOT`, `XS_IDLE`, `XS_STORE`, `XS_RECALL`). Its transitions are:
- reset enters `XS_BOOT`.
- `XS_BOOT` moves to `XS_IDLE` when the timer expires, copying shadow to volatile.
- `XS_IDLE` moves to `XS_STORE` on `save_req`. A save wins when both commands are high.
- `XS_IDLE` moves to `XS_RECALL` on `restore_req` alone.
- `XS_STORE` and `XS_RECALL` return to `XS_IDLE` when the timer expires, performing the copy on that edge.

Top module: `shsram_top`

## Requirements
- R1: When `ce_n`=0, `oe_n`=0, `we_n`=1, `hold_n`=1 and `busy`=0, a lane whose select is low is driven. `lane_oe[1]`/`rdata[15:8]` belong to `ub_n` and `lane_oe[0]`/`rdata[7:0]` belong to `lb_n`. A driven lane shows the volatile word at `addr`. An undriven lane has its `lane_oe` bit at 0 and reads as 0.
- R2: On a rising edge with `ce_n`=0, `we_n`=0, `hold_n`=1 and `busy`=0, only the lanes whose select is low take `wdata`. The other lane of the word keeps its value.
- R3: With `hold_n`=0 or `ce_n`=1, no lane is driven and no write changes the volatile array.
- R4: A save command sampled in `XS_IDLE` copies the whole volatile array into the shadow. A restore command copies the whole shadow into the volatile array. In both cases `busy` is high for exactly `XFER_CYCLES` cycles starting the cycle after the command. A save wins when both commands are high.
- R5: While `busy` is high, no lane is driven, host writes are dropped, and further commands are ignored.
- R6: While `we_n`=0, both lanes are released (`lane_oe`=0) even if `oe_n`=0.
- R7: `save_count` goes up by one per completed save and never by a restore. It saturates at `STORE_LIMIT`+1. `wear_out` is 1 exactly when the count exceeds `STORE_LIMIT`.
- R8: While the read conditions hold, `rdata` follows `addr` changes with no change on any control input.
- R9: Reset clears `save_count` and enters `XS_BOOT`. `busy` stays high for `XFER_CYCLES` cycles after reset release, then the volatile array holds the shadow contents. The shadow keeps its contents through reset and starts as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hold_n | input | 1 | Host hold, low blocks all access |
| ub_n | input | 1 | Upper byte lane select, active low |
| lb_n | input | 1 | Lower byte lane select, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| save_req | input | 1 | Command: copy volatile to shadow |
| restore_req | input | 1 | Command: copy shadow to volatile |
| rdata | output | 16 | Read data, 0 on undriven lanes |
| lane_oe | output | 2 | Per-lane drive enable (1 = driven, 0 = high impedance) |
| busy | output | 1 | Transfer or boot restore in progress |
| save_count | output | CNT_W | Saturating count of completed saves |
| wear_out | output | 1 | Save count above endurance limit |

## Verification
The copy paths are tested by checking which array a later read reflects. The bench writes a pattern, saves, overwrites, and then either restores or resets. Only the shadowed pattern may come back; a copy in the wrong direction, or a copy of only part of the array, returns the overwritten data. Stimulus during a transfer (a read, a write and a second save command) separates a correct lockout from a leak, both through the data read back afterwards and through a count that grows by exactly one. Writes on a single lane, reads on a single lane, and writes blocked by hold or chip select each tell byte-lane masking apart from whole-word behaviour. A run of saves past the limit shows where the count saturates and when the wear flag rises.

// File: rtl/shsram_pkg.sv
package shsram_pkg;

    // Controller states of the shadowed memory
    typedef enum logic [1:0] {
        XS_BOOT   = 2'd0,
        XS_IDLE   = 2'd1,
        XS_STORE  = 2'd2,
        XS_RECALL = 2'd3
    } xfer_state_t;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;

endpackage

// File: rtl/shsram_ctrl.sv
module shsram_ctrl
    import shsram_pkg::*;
#(
    parameter int XFER_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic save_req,
    input  logic restore_req,
    output logic busy,
    output logic store_pulse,
    output logic recall_pulse
);

    localparam int TW = (XFER_CYCLES < 2) ? 1 : $clog2(XFER_CYCLES);
    localparam logic [TW-1:0] T_LOAD = TW'(XFER_CYCLES - 1);

    xfer_state_t state_q, state_d;
    logic [TW-1:0] timer_q, timer_d;
    logic          expired;

    assign expired = (timer_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        unique case (state_q)
            XS_IDLE: begin
                if (save_req) begin
                    state_d = XS_STORE;
                    timer_d = T_LOAD;
                end else if (restore_req) begin
                    state_d = XS_RECALL;
                    timer_d = T_LOAD;
                end
            end
            XS_BOOT, XS_STORE, XS_RECALL: begin
                if (expired) state_d = XS_IDLE;
                else         timer_d = timer_q - 1'b1;
            end
            default: state_d = XS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XS_BOOT;
            timer_q <= T_LOAD;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
        end
    end

    // outputs
    always_comb begin
        busy         = 1'b1;
        store_pulse  = 1'b0;
        recall_pulse = 1'b0;
        unique case (state_q)
            XS_IDLE:   busy = 1'b0;
            XS_STORE:  store_pulse = expired;
            XS_BOOT,
            XS_RECALL: recall_pulse = expired;
            default:   busy = 1'b1;
        endcase
    end

    p_store_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_IDLE && save_req) |=> (state_q == XS_STORE));

    p_recall_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_IDLE && !save_req && restore_req) |=> (state_q == XS_RECALL));

    p_copy_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_pulse, recall_pulse}));

    p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == XS_STORE && !expired) |=> (state_q == XS_STORE));

endmodule

// File: rtl/shsram_lane.sv
module shsram_lane #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4,
    parameter int WIDTH  = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic              store_pulse,
    input  logic              recall_pulse,
    output logic [WIDTH-1:0]  rdata
);

    logic [WIDTH-1:0] vol_q    [DEPTH];
    logic [WIDTH-1:0] shadow_q [DEPTH];

    // shadow starts erased; it is never touched by reset
    initial begin
        for (int i = 0; i < DEPTH; i++) shadow_q[i] = '0;
    end

    always_ff @(posedge clk) begin
        if (recall_pulse) begin
            for (int i = 0; i < DEPTH; i++) vol_q[i] <= shadow_q[i];
        end else if (wr_en) begin
            vol_q[addr] <= wdata;
        end
        if (store_pulse) begin
            for (int i = 0; i < DEPTH; i++) shadow_q[i] <= vol_q[i];
        end
    end

    assign rdata = vol_q[addr];

endmodule

// File: rtl/shsram_wear.sv
module shsram_wear #(
    parameter int STORE_LIMIT = 200000,
    parameter int CNT_W       = $clog2(STORE_LIMIT + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_pulse,
    output logic [CNT_W-1:0] count,
    output logic             worn
);

    localparam logic [CNT_W-1:0] CAP   = CNT_W'(STORE_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(STORE_LIMIT);

    logic [CNT_W-1:0] count_q;
    logic             at_cap;

    assign at_cap = (count_q == CAP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     count_q <= '0;
        else if (store_pulse && !at_cap) count_q <= count_q + 1'b1;
    end

    assign count = count_q;
    assign worn  = (count_q > LIMIT);

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (store_pulse && !at_cap) |=> (count_q == $past(count_q) + 1'b1));

    p_count_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        at_cap |=> (count_q == CAP));

    p_count_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !store_pulse |=> $stable(count_q));

endmodule

// File: rtl/shsram_top.sv
module shsram_top
    import shsram_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int XFER_CYCLES = 4,
    parameter int STORE_LIMIT = 200000,
    localparam int ADDR_W     = $clog2(DEPTH),
    localparam int CNT_W      = $clog2(STORE_LIMIT + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              hold_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              save_req,
    input  logic              restore_req,
    output logic [15:0]       rdata,
    output logic [1:0]        lane_oe,
    output logic              busy,
    output logic [CNT_W-1:0]  save_count,
    output logic              wear_out
);

    logic             store_pulse, recall_pulse;
    logic             rd_ok, wr_ok;
    logic [LANES-1:0] lane_sel_n;
    logic [LANE_W-1:0] lane_rd [LANES];

    assign lane_sel_n = {ub_n, lb_n};
    assign rd_ok = !ce_n && !oe_n &&  we_n && hold_n && !busy;
    assign wr_ok = !ce_n && !we_n && hold_n && !busy;

    shsram_ctrl #(.XFER_CYCLES(XFER_CYCLES)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .save_req     (save_req),
        .restore_req  (restore_req),
        .busy         (busy),
        .store_pulse  (store_pulse),
        .recall_pulse (recall_pulse)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        shsram_lane #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_lane (
            .clk          (clk),
            .wr_en        (wr_ok && !lane_sel_n[g]),
            .addr         (addr),
            .wdata        (wdata[g*LANE_W +: LANE_W]),
            .store_pulse  (store_pulse),
            .recall_pulse (recall_pulse),
            .rdata        (lane_rd[g])
        );
        assign lane_oe[g] = rd_ok && !lane_sel_n[g];
        assign rdata[g*LANE_W +: LANE_W] = lane_oe[g] ? lane_rd[g] : '0;
    end

    shsram_wear #(.STORE_LIMIT(STORE_LIMIT), .CNT_W(CNT_W)) u_wear (
        .clk         (clk),
        .rst_n       (rst_n),
        .store_pulse (store_pulse),
        .count       (save_count),
        .worn        (wear_out)
    );

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (lane_oe == 2'b00));

    p_busy_noread_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (lane_oe == 2'b00));

    p_hold_noread_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n || ce_n) |-> (lane_oe == 2'b00));

endmodule

// File: tb/sim_shsram_top.sv
module sim_shsram_top;

    localparam int DEPTH = 16;
    localparam int XFER  = 3;
    localparam int LIMIT = 3;
    localparam int AW    = 4;
    localparam int CW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hold_n = 1'b1;
    logic ub_n = 1'b0, lb_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0] wdata = '0;
    logic save_req = 1'b0, restore_req = 1'b0;
    logic [15:0] rdata;
    logic [1:0]  lane_oe;
    logic        busy;
    logic [CW-1:0] save_count;
    logic        wear_out;

    int n_chk = 0;
    int n_bad = 0;
    int exp_cnt = 0;
    logic [15:0] vol_m [DEPTH];
    logic [15:0] sh_m  [DEPTH];

    always #5 clk = ~clk;

    shsram_top #(.DEPTH(DEPTH), .XFER_CYCLES(XFER), .STORE_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .hold_n(hold_n), .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .wdata(wdata),
        .save_req(save_req), .restore_req(restore_req), .rdata(rdata),
        .lane_oe(lane_oe), .busy(busy), .save_count(save_count), .wear_out(wear_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_ctl();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; hold_n = 1'b1;
        ub_n = 1'b0; lb_n = 1'b0; save_req = 1'b0; restore_req = 1'b0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d,
                            input logic u_n, input logic l_n);
        ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d; ub_n = u_n; lb_n = l_n;
        @(posedge clk);
        @(negedge clk);
        idle_ctl();
    endtask

    task automatic read_chk(input string tag, input logic [AW-1:0] a, input logic u_n,
                            input logic l_n, input logic [15:0] exp_d, input logic [1:0] exp_oe);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a; ub_n = u_n; lb_n = l_n;
        #1;
        check({tag, " data"}, 32'(rdata), 32'(exp_d));
        check({tag, " lane_oe"}, 32'(lane_oe), 32'(exp_oe));
        idle_ctl();
    endtask

    // wait the rest of a transfer started at the previous edge, checking busy
    task automatic finish_xfer(input string tag);
        check({tag, " busy at start"}, 32'(busy), 32'd1);
        for (int k = 1; k <= XFER; k++) begin
            @(negedge clk);
            check({tag, " busy window"}, 32'(busy), (k < XFER) ? 32'd1 : 32'd0);
        end
    endtask

    task automatic t_reset_boot(input string tag);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check({tag, " R9 count cleared"}, 32'(save_count), 32'd0);
        rst_n = 1'b1;
        exp_cnt = 0;
        for (int i = 0; i < DEPTH; i++) vol_m[i] = sh_m[i];
        finish_xfer({tag, " R9"});
        for (int i = 0; i < DEPTH; i += 5)
            read_chk({tag, " R9 boot contents"}, AW'(i), 1'b0, 1'b0, vol_m[i], 2'b11);
    endtask

    task automatic t_write_read();
        for (int i = 0; i < DEPTH; i++) begin
            vol_m[i] = 16'hA000 + 16'(i * 16'h0111);
            do_write(AW'(i), vol_m[i], 1'b0, 1'b0);
        end
        for (int i = 0; i < DEPTH; i += 3)
            read_chk("R1/R2 full word", AW'(i), 1'b0, 1'b0, vol_m[i], 2'b11);
        // R8: change address only while read conditions hold
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        for (int i = 2; i < 6; i++) begin
            addr = AW'(i);
            #1;
            check("R8 follows addr", 32'(rdata), 32'(vol_m[i]));
        end
        idle_ctl();
    endtask

    task automatic t_lanes();
        do_write(4'd3, 16'h5AC3, 1'b0, 1'b1);
        vol_m[3] = {8'h5A, vol_m[3][7:0]};
        do_write(4'd7, 16'h11E4, 1'b1, 1'b0);
        vol_m[7] = {vol_m[7][15:8], 8'hE4};
        read_chk("R2 upper lane only", 4'd3, 1'b0, 1'b0, vol_m[3], 2'b11);
        read_chk("R2 lower lane only", 4'd7, 1'b0, 1'b0, vol_m[7], 2'b11);
        read_chk("R1 lower lane read", 4'd3, 1'b1, 1'b0, {8'h00, vol_m[3][7:0]}, 2'b01);
        read_chk("R1 upper lane read", 4'd7, 1'b0, 1'b1, {vol_m[7][15:8], 8'h00}, 2'b10);
        read_chk("R1 no lane", 4'd7, 1'b1, 1'b1, 16'h0000, 2'b00);
    endtask

    task automatic t_inhibit();
        hold_n = 1'b0;
        do_write(4'd1, 16'hDEAD, 1'b0, 1'b0);
        ce_n = 1'b1; we_n = 1'b0; addr = 4'd2; wdata = 16'hBEEF;
        @(posedge clk); @(negedge clk);
        idle_ctl();
        read_chk("R3 hold blocks write", 4'd1, 1'b0, 1'b0, vol_m[1], 2'b11);
        read_chk("R3 ce_n blocks write", 4'd2, 1'b0, 1'b0, vol_m[2], 2'b11);
        hold_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; addr = 4'd1;
        #1;
        check("R3 hold blocks read", 32'(lane_oe), 32'd0);
        idle_ctl();
    endtask

    task automatic t_we_release();
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; addr = 4'd9; wdata = 16'h7E57;
        #1;
        check("R6 released during write", 32'(lane_oe), 32'd0);
        check("R6 data zero during write", 32'(rdata), 32'd0);
        @(posedge clk); @(negedge clk);
        idle_ctl();
        vol_m[9] = 16'h7E57;
        read_chk("R6 write with oe low lands", 4'd9, 1'b0, 1'b0, vol_m[9], 2'b11);
    endtask

    task automatic t_store_recall();
        save_req = 1'b1;
        @(posedge clk); @(negedge clk);
        save_req = 1'b0;
        for (int i = 0; i < DEPTH; i++) sh_m[i] = vol_m[i];
        exp_cnt++;
        check("R4 busy after save", 32'(busy), 32'd1);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 4'd0;
        #1;
        check("R5 no read while busy", 32'(lane_oe), 32'd0);
        we_n = 1'b0; oe_n = 1'b1; wdata = 16'h0BAD; save_req = 1'b1;
        for (int k = 1; k <= XFER; k++) begin
            @(negedge clk);
            idle_ctl();
            check("R4 busy window", 32'(busy), (k < XFER) ? 32'd1 : 32'd0);
        end
        #1;
        check("R5 extra save ignored", 32'(save_count), 32'(exp_cnt));
        read_chk("R5 write dropped", 4'd0, 1'b0, 1'b0, vol_m[0], 2'b11);
        // overwrite then restore
        for (int i = 0; i < DEPTH; i += 2) begin
            vol_m[i] = 16'h3300 ^ 16'(i);
            do_write(AW'(i), vol_m[i], 1'b0, 1'b0);
        end
        read_chk("R2 overwrite seen", 4'd4, 1'b0, 1'b0, vol_m[4], 2'b11);
        save_req = 1'b0; restore_req = 1'b1;
        @(posedge clk); @(negedge clk);
        restore_req = 1'b0;
        for (int i = 0; i < DEPTH; i++) vol_m[i] = sh_m[i];
        finish_xfer("R4 restore");
        for (int i = 0; i < DEPTH; i += 2)
            read_chk("R4 restored word", AW'(i), 1'b0, 1'b0, vol_m[i], 2'b11);
        check("R7 restore not counted", 32'(save_count), 32'(exp_cnt));
    endtask

    task automatic t_both_cmds();
        vol_m[5] = 16'hC0DE;
        do_write(4'd5, vol_m[5], 1'b0, 1'b0);
        save_req = 1'b1; restore_req = 1'b1;
        @(posedge clk); @(negedge clk);
        idle_ctl();
        for (int i = 0; i < DEPTH; i++) sh_m[i] = vol_m[i];
        exp_cnt++;
        finish_xfer("R4 save wins");
        #1;
        check("R4 save wins count", 32'(save_count), 32'(exp_cnt));
        read_chk("R4 save wins data", 4'd5, 1'b0, 1'b0, 16'hC0DE, 2'b11);
    endtask

    task automatic t_reset_keep();
        vol_m[6] = 16'h0F0F;
        do_write(4'd6, vol_m[6], 1'b0, 1'b0);
        t_reset_boot("R9 keep");
        read_chk("R9 shadow survives", 4'd6, 1'b0, 1'b0, sh_m[6], 2'b11);
    endtask

    task automatic t_wear();
        for (int n = 1; n <= LIMIT + 2; n++) begin
            save_req = 1'b1;
            @(posedge clk); @(negedge clk);
            save_req = 1'b0;
            repeat (XFER) @(negedge clk);
            if (exp_cnt < LIMIT + 1) exp_cnt++;
            #1;
            check("R7 save count", 32'(save_count), 32'(exp_cnt));
            check("R7 wear flag", 32'(wear_out), (exp_cnt > LIMIT) ? 32'd1 : 32'd0);
        end
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) sh_m[i] = '0;
        idle_ctl();
        @(negedge clk);
        t_reset_boot("R9 power-on");
        t_write_read();
        t_lanes();
        t_inhibit();
        t_we_release();
        t_store_recall();
        t_both_cmds();
        t_reset_keep();
        t_wear();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule